// File: doc/BRIEF.md
# 64-bit Integer Execution Unit with Bit-Manipulation Operations

This block is the integer datapath of a 64-bit execution pipeline. It takes two 64-bit source operands and a 7-bit operation code, and produces one 64-bit result. The operations cover shifts and rotates, single-bit edits, 32-bit word arithmetic with sign extension, fused shift-and-add address forms, comparisons and min/max, branch conditions, conditional zeroing, inverted-operand logic, byte-wise OR-combine, byte swap and sign extension.

The three top bits of the operation code select a family. Three sub-units decode the full code in parallel. Each sub-unit drives zero for any code it does not own, so the top merges the three outputs with a plain OR. A parameter selects whether the result is registered once, which is the default, or driven combinationally. Decoding from instruction bits, operand forwarding, multiply and divide are handled outside this block.

Top module: `rv64_int_alu`

## Requirements
- R1: With `OUT_REG`=1, `result` is 0 while `rst` is high and in the first cycle after reset is released. In every later cycle, `result` shows the outcome of the inputs present at the previous rising clock edge.
- R2: Shift and rotate codes use `src_b[5:0]` as the amount:
  - 0x01 shifts left and 0x05 shifts right logically.
  - 0x07 shifts right arithmetically.
  - 0x09 rotates left and 0x0B rotates right, within 64 bits.
  - 0x00 zero-extends `src_a[31:0]` and then shifts it left.
- R3: Single-bit codes act on bit `src_b[5:0]` of `src_a`: 0x02 clears it, 0x03 sets it and 0x04 inverts it. Code 0x06 returns that bit as the value 0 or 1.
- R4: Word codes compute a 32-bit value and sign-extend it to 64 bits:
  - 0x10 adds and 0x12 subtracts.
  - 0x11 adds `src_a[0]` to `src_b`.
  - 0x13 is the fused immediate add done in 32 bits (see R7).
  - 0x18, 0x19 and 0x1A shift `src_a[31:0]` left, right logically and right arithmetically by `src_b[4:0]`.
  - 0x1C rotates `src_a[31:0]` left and 0x1D rotates it right, by `src_b[4:0]`.
- R5: Codes 0x14, 0x15, 0x16 and 0x17 return parts of `src_a+src_b`: 0x14 gives bit 0, 0x15 gives bits [7:0] and 0x16 gives bits [15:0] zero-extended. 0x17 gives bits [15:0] sign-extended.
- R6: Code 0x21 returns `src_a+src_b` and 0x20 returns the zero-extended `src_a[31:0]` plus `src_b`. Codes 0x29, 0x2B, 0x2D and 0x2F return `src_b` plus `src_a` shifted left by 1, 2, 3 and 4. Codes 0x28, 0x2A and 0x2C do the same with the zero-extended `src_a[31:0]`, shifted by 1, 2 and 3.
- R7: Codes 0x24 to 0x27 return `src_b` plus `src_a` logically shifted right by 29, 30, 31 and 32. Code 0x22 returns `src_b+src_a[0]`. Code 0x23 returns the sign-extended `src_b[11:0]` plus `src_b` with its low 12 bits cleared.
- R8: Code 0x30 returns `src_a-src_b`. Codes 0x31 (unsigned) and 0x32 (signed) return 1 when `src_a<src_b`, otherwise 0. Codes 0x34 and 0x36 return the unsigned and signed maximum. Codes 0x35 and 0x37 return the unsigned and signed minimum.
- R9: Logic codes:
  - 0x40 is AND, 0x42 is OR and 0x44 is XOR.
  - 0x41 is `src_a & ~src_b`, 0x43 is `src_a | ~src_b` and 0x45 is XNOR.
  - 0x46 sets each byte of `src_a` to 0xFF if any bit of that byte is set, otherwise to 0x00.
  - 0x48 sign-extends byte 0 of `src_a` and 0x4A sign-extends halfword 0.
  - 0x51 reverses the byte order of `src_a`.
- R10: Codes 0x60 to 0x67 reduce a logic result. Bits [2:1] pick the operation: 0 is AND, 1 is OR, 2 is XOR and 3 is the byte OR-combine of `src_a`. Bit 0 picks the output form: 0 returns bit 0 of the operation's result, and 1 returns its bits [15:0] zero-extended.
- R11: Branch codes return 1 when the condition holds, otherwise 0: 0x70 equal, 0x72 not equal, 0x78 signed less-than, 0x7A signed greater-or-equal, 0x7C unsigned less-than and 0x7E unsigned greater-or-equal.
- R12: Code 0x74 returns 0 when `src_b` is zero, otherwise `src_a`. Code 0x76 returns 0 when `src_b` is nonzero, otherwise `src_a`.
- R13: Every code not listed in R2 to R12 returns 0. Examples are 0x08, 0x1B, 0x2E, 0x33, 0x50, 0x68 and 0x7F.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset, clears the result |
| op_i | input | 7 | Operation code; bits [6:4] select the family |
| src_a | input | XLEN | First source operand |
| src_b | input | XLEN | Second source operand or shift amount |
| result | output | XLEN | Operation result, registered when OUT_REG=1 |

## Verification
The bench goes after the edges of shift amounts:
- A rotate by 0 or by 63 exposes a design whose rotate overshoots or leaves stale bits.
- A word shift with `src_b`=0x3F shows whether bit 5 leaks into the 32-bit amount.

Word sums that overflow into bit 31 show whether bits [63:32] are really sign-extended. Operands at the sign boundary separate signed from unsigned comparisons, in min/max and in branches alike. Unlisted codes are sent in next to valid neighbours, such as 0x2E beside the fused shift-add group and 0x68 beside the reduced-logic group. A decoder that aliases them would return a value other than zero.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [2:0] {
    FAM_SHIFT  = 3'b000,
    FAM_WORD   = 3'b001,
    FAM_ADD    = 3'b010,
    FAM_CMP    = 3'b011,
    FAM_LOGIC  = 3'b100,
    FAM_PERM   = 3'b101,
    FAM_REDUCE = 3'b110,
    FAM_COND   = 3'b111
  } fam_e;

  // shift / single bit
  localparam logic [6:0] OP_SHL_UW   = 7'h00;
  localparam logic [6:0] OP_SHL      = 7'h01;
  localparam logic [6:0] OP_BIT_CLR  = 7'h02;
  localparam logic [6:0] OP_BIT_SET  = 7'h03;
  localparam logic [6:0] OP_BIT_FLIP = 7'h04;
  localparam logic [6:0] OP_SHR      = 7'h05;
  localparam logic [6:0] OP_BIT_GET  = 7'h06;
  localparam logic [6:0] OP_SHRA     = 7'h07;
  localparam logic [6:0] OP_ROT_L    = 7'h09;
  localparam logic [6:0] OP_ROT_R    = 7'h0B;

  // 32-bit word
  localparam logic [6:0] OP_W_ADD     = 7'h10;
  localparam logic [6:0] OP_W_ADD_ODD = 7'h11;
  localparam logic [6:0] OP_W_SUB     = 7'h12;
  localparam logic [6:0] OP_W_IMM_ADD = 7'h13;
  localparam logic [6:0] OP_W_ADD_B1  = 7'h14;
  localparam logic [6:0] OP_W_ADD_B8  = 7'h15;
  localparam logic [6:0] OP_W_ADD_ZH  = 7'h16;
  localparam logic [6:0] OP_W_ADD_SH  = 7'h17;
  localparam logic [6:0] OP_W_SHL     = 7'h18;
  localparam logic [6:0] OP_W_SHR     = 7'h19;
  localparam logic [6:0] OP_W_SHRA    = 7'h1A;
  localparam logic [6:0] OP_W_ROT_L   = 7'h1C;
  localparam logic [6:0] OP_W_ROT_R   = 7'h1D;

  // add variants
  localparam logic [6:0] OP_ADD_UW    = 7'h20;
  localparam logic [6:0] OP_ADD       = 7'h21;
  localparam logic [6:0] OP_ADD_ODD   = 7'h22;
  localparam logic [6:0] OP_IMM_ADD   = 7'h23;
  localparam logic [6:0] OP_SR29_ADD  = 7'h24;
  localparam logic [6:0] OP_SR30_ADD  = 7'h25;
  localparam logic [6:0] OP_SR31_ADD  = 7'h26;
  localparam logic [6:0] OP_SR32_ADD  = 7'h27;
  localparam logic [6:0] OP_SH1_ADDUW = 7'h28;
  localparam logic [6:0] OP_SH1_ADD   = 7'h29;
  localparam logic [6:0] OP_SH2_ADDUW = 7'h2A;
  localparam logic [6:0] OP_SH2_ADD   = 7'h2B;
  localparam logic [6:0] OP_SH3_ADDUW = 7'h2C;
  localparam logic [6:0] OP_SH3_ADD   = 7'h2D;
  localparam logic [6:0] OP_SH4_ADD   = 7'h2F;

  // subtract / compare
  localparam logic [6:0] OP_SUB   = 7'h30;
  localparam logic [6:0] OP_LT_U  = 7'h31;
  localparam logic [6:0] OP_LT_S  = 7'h32;
  localparam logic [6:0] OP_MAX_U = 7'h34;
  localparam logic [6:0] OP_MIN_U = 7'h35;
  localparam logic [6:0] OP_MAX_S = 7'h36;
  localparam logic [6:0] OP_MIN_S = 7'h37;

  // logic / permute
  localparam logic [6:0] OP_AND      = 7'h40;
  localparam logic [6:0] OP_AND_INV  = 7'h41;
  localparam logic [6:0] OP_OR       = 7'h42;
  localparam logic [6:0] OP_OR_INV   = 7'h43;
  localparam logic [6:0] OP_XOR      = 7'h44;
  localparam logic [6:0] OP_XNOR     = 7'h45;
  localparam logic [6:0] OP_BYTE_OR  = 7'h46;
  localparam logic [6:0] OP_SEXT8    = 7'h48;
  localparam logic [6:0] OP_SEXT16   = 7'h4A;
  localparam logic [6:0] OP_BSWAP    = 7'h51;

  // branch condition / conditional zero
  localparam logic [6:0] OP_BR_EQ   = 7'h70;
  localparam logic [6:0] OP_BR_NE   = 7'h72;
  localparam logic [6:0] OP_ZERO_EQZ = 7'h74;
  localparam logic [6:0] OP_ZERO_NEZ = 7'h76;
  localparam logic [6:0] OP_BR_LT   = 7'h78;
  localparam logic [6:0] OP_BR_GE   = 7'h7A;
  localparam logic [6:0] OP_BR_LTU  = 7'h7C;
  localparam logic [6:0] OP_BR_GEU  = 7'h7E;

endpackage

// File: rtl/alu_shift_unit.sv
module alu_shift_unit
  import alu_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [6:0]                 op,
  input  logic [XLEN-1:0]            a,
  input  logic [$clog2(XLEN)-1:0]    amt_src,
  output logic [XLEN-1:0]            res
);
  localparam int SW  = $clog2(XLEN);
  localparam int HW  = XLEN / 2;
  localparam int HSW = SW - 1;

  logic [SW-1:0]   amt;
  logic [HSW-1:0]  wamt;
  logic [XLEN-1:0] onehot, a_lo_z, rol_v, ror_v, sra_v;
  logic [HW-1:0]   wa, sllw_v, srlw_v, sraw_v, rolw_v, rorw_v;

  always_comb begin
    amt    = amt_src;
    wamt   = amt_src[HSW-1:0];
    onehot = {{(XLEN-1){1'b0}}, 1'b1} << amt;
    a_lo_z = {{HW{1'b0}}, a[HW-1:0]};
    rol_v  = (a << amt) | (a >> (XLEN - int'(amt)));
    ror_v  = (a >> amt) | (a << (XLEN - int'(amt)));
    sra_v  = $signed(a) >>> amt;
    wa     = a[HW-1:0];
    sllw_v = wa << wamt;
    srlw_v = wa >> wamt;
    sraw_v = $signed(wa) >>> wamt;
    rolw_v = (wa << wamt) | (wa >> (HW - int'(wamt)));
    rorw_v = (wa >> wamt) | (wa << (HW - int'(wamt)));

    case (op)
      OP_SHL_UW:   res = a_lo_z << amt;
      OP_SHL:      res = a << amt;
      OP_BIT_CLR:  res = a & ~onehot;
      OP_BIT_SET:  res = a | onehot;
      OP_BIT_FLIP: res = a ^ onehot;
      OP_SHR:      res = a >> amt;
      OP_BIT_GET:  res = {{(XLEN-1){1'b0}}, |(a & onehot)};
      OP_SHRA:     res = sra_v;
      OP_ROT_L:    res = rol_v;
      OP_ROT_R:    res = ror_v;
      OP_W_SHL:    res = {{HW{sllw_v[HW-1]}}, sllw_v};
      OP_W_SHR:    res = {{HW{srlw_v[HW-1]}}, srlw_v};
      OP_W_SHRA:   res = {{HW{sraw_v[HW-1]}}, sraw_v};
      OP_W_ROT_L:  res = {{HW{rolw_v[HW-1]}}, rolw_v};
      OP_W_ROT_R:  res = {{HW{rorw_v[HW-1]}}, rorw_v};
      default:     res = '0;
    endcase
  end
endmodule

// File: rtl/alu_arith_unit.sv
module alu_arith_unit
  import alu_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [6:0]      op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] res
);
  localparam int HW      = XLEN / 2;
  localparam int SR_BASE = HW - 3;

  logic [XLEN-1:0] sum, diff, odd_sum, uw_a, imm_full, sr_sum, sh_base, sh_sum;
  logic [HW-1:0]   imm_word;
  logic [2:0]      shn;
  logic            eq, ltu, lts, bzero;

  always_comb begin
    sum      = a + b;
    diff     = a - b;
    odd_sum  = b + {{(XLEN-1){1'b0}}, a[0]};
    uw_a     = {{HW{1'b0}}, a[HW-1:0]};
    imm_full = {{(XLEN-12){b[11]}}, b[11:0]} + {b[XLEN-1:12], 12'h000};
    imm_word = {{(HW-12){b[11]}}, b[11:0]} + {b[HW-1:12], 12'h000};
    sr_sum   = (a >> (SR_BASE + int'(op[1:0]))) + b;
    shn      = {1'b0, op[2:1]} + 3'd1;
    sh_base  = op[0] ? a : uw_a;
    sh_sum   = (sh_base << shn) + b;
    eq       = (a == b);
    ltu      = (a < b);
    lts      = ($signed(a) < $signed(b));
    bzero    = (b == '0);

    case (op)
      OP_W_ADD:     res = {{HW{sum[HW-1]}}, sum[HW-1:0]};
      OP_W_ADD_ODD: res = {{HW{odd_sum[HW-1]}}, odd_sum[HW-1:0]};
      OP_W_SUB:     res = {{HW{diff[HW-1]}}, diff[HW-1:0]};
      OP_W_IMM_ADD: res = {{HW{imm_word[HW-1]}}, imm_word};
      OP_W_ADD_B1:  res = {{(XLEN-1){1'b0}}, sum[0]};
      OP_W_ADD_B8:  res = {{(XLEN-8){1'b0}}, sum[7:0]};
      OP_W_ADD_ZH:  res = {{(XLEN-16){1'b0}}, sum[15:0]};
      OP_W_ADD_SH:  res = {{(XLEN-16){sum[15]}}, sum[15:0]};
      OP_ADD_UW:    res = uw_a + b;
      OP_ADD:       res = sum;
      OP_ADD_ODD:   res = odd_sum;
      OP_IMM_ADD:   res = imm_full;
      OP_SR29_ADD, OP_SR30_ADD, OP_SR31_ADD, OP_SR32_ADD:
                    res = sr_sum;
      OP_SH1_ADDUW, OP_SH1_ADD, OP_SH2_ADDUW, OP_SH2_ADD,
      OP_SH3_ADDUW, OP_SH3_ADD, OP_SH4_ADD:
                    res = sh_sum;
      OP_SUB:       res = diff;
      OP_LT_U:      res = {{(XLEN-1){1'b0}}, ltu};
      OP_LT_S:      res = {{(XLEN-1){1'b0}}, lts};
      OP_MAX_U:     res = ltu ? b : a;
      OP_MIN_U:     res = ltu ? a : b;
      OP_MAX_S:     res = lts ? b : a;
      OP_MIN_S:     res = lts ? a : b;
      OP_BR_EQ:     res = {{(XLEN-1){1'b0}}, eq};
      OP_BR_NE:     res = {{(XLEN-1){1'b0}}, !eq};
      OP_BR_LT:     res = {{(XLEN-1){1'b0}}, lts};
      OP_BR_GE:     res = {{(XLEN-1){1'b0}}, !lts};
      OP_BR_LTU:    res = {{(XLEN-1){1'b0}}, ltu};
      OP_BR_GEU:    res = {{(XLEN-1){1'b0}}, !ltu};
      OP_ZERO_EQZ:  res = bzero ? '0 : a;
      OP_ZERO_NEZ:  res = bzero ? a : '0;
      default:      res = '0;
    endcase
  end
endmodule

// File: rtl/alu_logic_unit.sv
module alu_logic_unit
  import alu_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [6:0]      op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] res
);
  localparam int NBYTES = XLEN / 8;

  logic [XLEN-1:0] orcb_a, rev_a, red_v;

  for (genvar i = 0; i < NBYTES; i++) begin : g_byte
    assign orcb_a[8*i +: 8] = {8{|a[8*i +: 8]}};
    assign rev_a[8*i +: 8]  = a[XLEN-8-8*i +: 8];
  end

  always_comb begin
    case (op[2:1])
      2'd0:    red_v = a & b;
      2'd1:    red_v = a | b;
      2'd2:    red_v = a ^ b;
      default: red_v = orcb_a;
    endcase

    case (op)
      OP_AND:     res = a & b;
      OP_AND_INV: res = a & ~b;
      OP_OR:      res = a | b;
      OP_OR_INV:  res = a | ~b;
      OP_XOR:     res = a ^ b;
      OP_XNOR:    res = ~(a ^ b);
      OP_BYTE_OR: res = orcb_a;
      OP_SEXT8:   res = {{(XLEN-8){a[7]}}, a[7:0]};
      OP_SEXT16:  res = {{(XLEN-16){a[15]}}, a[15:0]};
      OP_BSWAP:   res = rev_a;
      default: begin
        if (op[6:3] == {FAM_REDUCE, 1'b0})
          res = op[0] ? {{(XLEN-16){1'b0}}, red_v[15:0]}
                      : {{(XLEN-1){1'b0}}, red_v[0]};
        else
          res = '0;
      end
    endcase
  end
endmodule

// File: rtl/rv64_int_alu.sv
module rv64_int_alu
  import alu_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter bit OUT_REG = 1'b1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [6:0]      op_i,
  input  logic [XLEN-1:0] src_a,
  input  logic [XLEN-1:0] src_b,
  output logic [XLEN-1:0] result
);
  localparam int SW = $clog2(XLEN);

  logic [XLEN-1:0] shift_res, arith_res, logic_res, result_c;

  alu_shift_unit #(.XLEN(XLEN)) u_shift (
    .op(op_i), .a(src_a), .amt_src(src_b[SW-1:0]), .res(shift_res)
  );

  alu_arith_unit #(.XLEN(XLEN)) u_arith (
    .op(op_i), .a(src_a), .b(src_b), .res(arith_res)
  );

  alu_logic_unit #(.XLEN(XLEN)) u_logic (
    .op(op_i), .a(src_a), .b(src_b), .res(logic_res)
  );

  // each unit drives zero for codes it does not own
  assign result_c = shift_res | arith_res | logic_res;

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) result <= '0;
      else     result <= result_c;
    end

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (result == '0));

    assert_word_sext_R4: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(op_i[6:4]) == FAM_WORD)
        |-> (result[XLEN-1:XLEN/2] == {(XLEN/2){result[XLEN/2-1]}}));

    assert_branch_bool_R11: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(op_i[6:4]) == FAM_COND && $past(op_i[3:2]) != 2'b01)
        |-> (result[XLEN-1:1] == '0));

    assert_czero_R12: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(op_i) == OP_ZERO_EQZ && $past(src_b) == '0)
        |-> (result == '0));

    assert_reduce_hole_R13: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(op_i[6:3]) == {FAM_REDUCE, 1'b1}) |-> (result == '0));
  end else begin : g_comb
    assign result = result_c;
  end
endmodule

// File: tb/rv64_int_alu_tb_top.sv
module rv64_int_alu_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic [6:0]  op_i;
  logic [63:0] src_a, src_b;
  logic [63:0] result;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  rv64_int_alu #(.XLEN(64), .OUT_REG(1'b1)) dut_i (
    .clk(clk), .rst(rst), .op_i(op_i), .src_a(src_a), .src_b(src_b), .result(result)
  );

  function automatic logic [63:0] sx32(input logic [31:0] x);
    return {{32{x[31]}}, x};
  endfunction

  function automatic logic [63:0] bytes_or(input logic [63:0] x);
    logic [63:0] r = '0;
    for (int i = 0; i < 8; i++) if (x[8*i +: 8] != 8'h00) r[8*i +: 8] = 8'hFF;
    return r;
  endfunction

  function automatic logic [63:0] bswap(input logic [63:0] x);
    logic [63:0] r;
    for (int i = 0; i < 8; i++) r[8*i +: 8] = x[8*(7-i) +: 8];
    return r;
  endfunction

  function automatic bit listed(input logic [6:0] op);
    case (op) inside
      [7'h00:7'h07], 7'h09, 7'h0B, [7'h10:7'h1A], 7'h1C, 7'h1D,
      [7'h20:7'h2D], 7'h2F, [7'h30:7'h32], [7'h34:7'h37],
      [7'h40:7'h46], 7'h48, 7'h4A, 7'h51, [7'h60:7'h67],
      7'h70, 7'h72, 7'h74, 7'h76, 7'h78, 7'h7A, 7'h7C, 7'h7E: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string tag_of(input logic [6:0] op);
    if (!listed(op)) return "R13";
    case (op[6:4])
      3'd0: return (op inside {7'h02, 7'h03, 7'h04, 7'h06}) ? "R3" : "R2";
      3'd1: return (op inside {[7'h14:7'h17]}) ? "R5" : "R4";
      3'd2: return (op inside {[7'h22:7'h27]}) ? "R7" : "R6";
      3'd3: return "R8";
      3'd6: return "R10";
      3'd7: return (op inside {7'h74, 7'h76}) ? "R12" : "R11";
      default: return "R9";
    endcase
  endfunction

  function automatic logic [63:0] model(input logic [6:0] op, input logic [63:0] a, input logic [63:0] b);
    logic [63:0] s  = a + b;
    logic [63:0] d  = a - b;
    int          sh = int'(b[5:0]);
    int          ws = int'(b[4:0]);
    logic [31:0] w  = a[31:0];
    logic [63:0] za = {32'h0, a[31:0]};
    logic [63:0] one = 64'd1 << sh;
    case (op)
      7'h00: return za << sh;
      7'h01: return a << sh;
      7'h02: return a & ~one;
      7'h03: return a | one;
      7'h04: return a ^ one;
      7'h05: return a >> sh;
      7'h06: return (a >> sh) & 64'd1;
      7'h07: return $signed(a) >>> sh;
      7'h09: return (a << sh) | (a >> (64 - sh));
      7'h0B: return (a >> sh) | (a << (64 - sh));
      7'h10: return sx32(s[31:0]);
      7'h11: return sx32(b[31:0] + {31'h0, a[0]});
      7'h12: return sx32(d[31:0]);
      7'h13: return sx32({{20{b[11]}}, b[11:0]} + {b[31:12], 12'h0});
      7'h14: return s & 64'h1;
      7'h15: return s & 64'hFF;
      7'h16: return s & 64'hFFFF;
      7'h17: return {{48{s[15]}}, s[15:0]};
      7'h18: return sx32(w << ws);
      7'h19: return sx32(w >> ws);
      7'h1A: return sx32($signed(w) >>> ws);
      7'h1C: return sx32((w << ws) | (w >> (32 - ws)));
      7'h1D: return sx32((w >> ws) | (w << (32 - ws)));
      7'h20: return za + b;
      7'h21: return s;
      7'h22: return b + {63'h0, a[0]};
      7'h23: return {{52{b[11]}}, b[11:0]} + {b[63:12], 12'h0};
      7'h24: return (a >> 29) + b;
      7'h25: return (a >> 30) + b;
      7'h26: return (a >> 31) + b;
      7'h27: return (a >> 32) + b;
      7'h28: return (za << 1) + b;
      7'h29: return (a << 1) + b;
      7'h2A: return (za << 2) + b;
      7'h2B: return (a << 2) + b;
      7'h2C: return (za << 3) + b;
      7'h2D: return (a << 3) + b;
      7'h2F: return (a << 4) + b;
      7'h30: return d;
      7'h31: return (a < b) ? 64'd1 : 64'd0;
      7'h32: return ($signed(a) < $signed(b)) ? 64'd1 : 64'd0;
      7'h34: return (a > b) ? a : b;
      7'h35: return (a < b) ? a : b;
      7'h36: return ($signed(a) > $signed(b)) ? a : b;
      7'h37: return ($signed(a) < $signed(b)) ? a : b;
      7'h40: return a & b;
      7'h41: return a & ~b;
      7'h42: return a | b;
      7'h43: return a | ~b;
      7'h44: return a ^ b;
      7'h45: return ~(a ^ b);
      7'h46: return bytes_or(a);
      7'h48: return {{56{a[7]}}, a[7:0]};
      7'h4A: return {{48{a[15]}}, a[15:0]};
      7'h51: return bswap(a);
      7'h60: return (a & b) & 64'h1;
      7'h61: return (a & b) & 64'hFFFF;
      7'h62: return (a | b) & 64'h1;
      7'h63: return (a | b) & 64'hFFFF;
      7'h64: return (a ^ b) & 64'h1;
      7'h65: return (a ^ b) & 64'hFFFF;
      7'h66: return bytes_or(a) & 64'h1;
      7'h67: return bytes_or(a) & 64'hFFFF;
      7'h70: return {63'h0, a == b};
      7'h72: return {63'h0, a != b};
      7'h78: return {63'h0, $signed(a) < $signed(b)};
      7'h7A: return {63'h0, $signed(a) >= $signed(b)};
      7'h7C: return {63'h0, a < b};
      7'h7E: return {63'h0, a >= b};
      7'h74: return (b == 64'h0) ? 64'h0 : a;
      7'h76: return (b != 64'h0) ? 64'h0 : a;
      default: return 64'h0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // inputs change at a falling edge; result is registered on the next rising edge
  task automatic run(input logic [6:0] op, input logic [63:0] a, input logic [63:0] b);
    op_i = op; src_a = a; src_b = b;
    @(negedge clk);
    check(tag_of(op), result, model(op, a, b), $sformatf("op=%h a=%h b=%h", op, a, b));
  endtask

  function automatic logic [63:0] pick();
    case ($urandom % 7)
      0: return 64'h0;
      1: return '1;
      2: return 64'h8000_0000_0000_0000;
      3: return 64'h0000_0000_8000_0000 | 64'($urandom % 4);
      4: return 64'($urandom % 80);
      default: return {$urandom, $urandom};
    endcase
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; op_i = 7'h21; src_a = 64'd5; src_b = 64'd7;
    repeat (3) @(negedge clk);
    check("R1", result, 64'h0, "result during reset");
    rst = 1'b0;
    #1 check("R1", result, 64'h0, "no combinational path after reset release");
    @(negedge clk);
    check("R1", result, 64'd12, "first result after reset");
    op_i = 7'h30;
    #1 check("R1", result, 64'd12, "result holds until the next edge");
    @(negedge clk);
    check("R1", result, 64'hFFFF_FFFF_FFFF_FFFE, "registered subtract");

    // R2 directed: rotates at amount 0 and 63, arithmetic shift of a negative value
    run(7'h09, 64'h8000_0000_0000_0001, 64'd0);
    run(7'h09, 64'h8000_0000_0000_0001, 64'd63);
    run(7'h0B, 64'h0123_4567_89AB_CDEF, 64'd63);
    run(7'h07, 64'h8000_0000_0000_0000, 64'h40 | 64'd63);
    run(7'h00, 64'hFFFF_FFFF_8000_0001, 64'd4);
    // R3 directed: top bit
    run(7'h06, 64'h8000_0000_0000_0000, 64'd63);
    run(7'h04, 64'h0, 64'd63);
    // R4 directed: overflow into bit 31, shift amount bit 5 must be ignored
    run(7'h10, 64'h0000_0000_7FFF_FFFF, 64'd1);
    run(7'h18, 64'h1, 64'h3F);
    run(7'h1A, 64'h0000_0000_8000_0000, 64'h3F);
    run(7'h1C, 64'h0000_0000_8000_0001, 64'd1);
    run(7'h13, 64'h0, 64'h0000_0000_7FFF_FFFF);
    // R5 directed
    run(7'h17, 64'h0000_0000_0000_7FFF, 64'd1);
    run(7'h16, 64'h0000_0000_0000_FFFF, 64'd2);
    // R6 / R7 directed
    run(7'h2F, 64'hF000_0000_0000_0001, 64'd3);
    run(7'h28, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0);
    run(7'h27, 64'hFFFF_FFFF_0000_0000, 64'd1);
    run(7'h23, 64'h0, 64'h0000_0000_0000_1800);
    // R8 directed: sign boundary
    run(7'h36, 64'h8000_0000_0000_0000, 64'd1);
    run(7'h34, 64'h8000_0000_0000_0000, 64'd1);
    run(7'h32, '1, 64'd0);
    // R9 / R10 directed
    run(7'h46, 64'h0100_0000_0080_0000, 64'd0);
    run(7'h51, 64'h0102_0304_0506_0708, 64'd0);
    run(7'h67, 64'h0000_0000_0000_0100, 64'd0);
    // R11 / R12 directed
    run(7'h78, '1, 64'd0);
    run(7'h7C, '1, 64'd0);
    run(7'h74, 64'hDEAD_BEEF, 64'd0);
    run(7'h76, 64'hDEAD_BEEF, 64'd0);
    run(7'h76, 64'hDEAD_BEEF, 64'd9);
    // R13 directed: holes beside valid neighbours
    run(7'h08, '1, '1);
    run(7'h2E, '1, '1);
    run(7'h68, '1, '1);
    run(7'h7F, '1, '1);

    for (int i = 0; i < 4000; i++) begin
      logic [6:0] op;
      op = 7'($urandom);
      if ($urandom % 4 != 0) while (!listed(op)) op = 7'($urandom);
      run(op, pick(), pick());
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule